// File: doc/BRIEF.md
# Memory-Backed General Register Controller

This block places the sixteen general registers of a 16-bit processor in on-chip RAM instead of flip-flops. A register read or write from the core is turned into a RAM word access. The RAM byte address comes from a relocatable bank base register combined with the register number. Moving the base therefore switches the whole register set to another window of RAM in one store. Register 15 serves as the stack pointer and registers 8 to 14 may serve as pointers. All sixteen use the same address mapping.

The block also carries the core's data memory port. Two word addresses on that port are decoded locally: the bank base register, which can be read and written, and a flags register, which can only be read and which packs five status bits supplied by the core. Every other address on that port passes through to the RAM. The RAM is modelled as synchronous with read-before-write behaviour. It has one read channel and one write channel. The register port has priority over the memory port for the RAM. A memory-port access that loses is held off with a stall.

Top module: `regwin_ctrl`

## Requirements
- R1: A register access to register number n (0 to 15) drives the RAM byte address (base AND 0xFFE0) OR (n * 2). Bit 0 is always 0 and bits 4:1 equal n.
- R2: When the bank base is written, bits 4:0 of the written value are discarded. A readback returns the written value with those five bits as zero.
- R3: After reset the bank base reads 0x0100, and an access to register 14 drives RAM address 0x011C.
- R4: The bank base is read and written at memory-port address 0xC002. A new base applies from the cycle after the write. A register access in the same cycle as the write still uses the previous base.
- R5: A read of memory-port address 0xC000 returns the flags word: zero at bit 0, carry at bit 1, overflow at bit 2, sign at bit 3, interrupt enable at bit 4, and zero in bits 15:5.
- R6: A write to 0xC000 has no effect. It asserts no RAM write, it leaves the bank base unchanged, and later flag reads still show only the core's flag inputs.
- R7: Register read data appears on `rd_data` one cycle after `rd_req`, and `rd_valid` is high in that cycle.
- R8: A register read and a register write to the same register in the same cycle return the value held before the write.
- R9: A memory-port access to any other address goes to the RAM at that address with bit 0 cleared. Read data returns one cycle later, with `mem_rvalid` high.
- R10: If the memory port targets the RAM while the register port is requesting, `cw_stall` is high and the memory port drives no RAM access. Accesses to 0xC000 and 0xC002 never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Register read request |
| rd_sel | input | 4 | Register number to read |
| rd_data | output | 16 | Register read data, valid with rd_valid |
| rd_valid | output | 1 | Register read data valid (one cycle after rd_req) |
| wr_req | input | 1 | Register write request |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 16 | Register write data |
| cw_req | input | 1 | Memory-port request |
| cw_we | input | 1 | Memory-port write (1) or read (0) |
| cw_addr | input | 16 | Memory-port byte address |
| cw_wdata | input | 16 | Memory-port write data |
| cw_stall | output | 1 | Memory-port request held this cycle |
| mem_rdata | output | 16 | Memory-port read data |
| mem_rvalid | output | 1 | Memory-port read data valid |
| flag_zero | input | 1 | Zero flag from core |
| flag_carry | input | 1 | Carry/borrow flag from core |
| flag_ovf | input | 1 | Overflow flag from core |
| flag_sign | input | 1 | Sign flag from core |
| flag_ie | input | 1 | Global interrupt enable from core |
| ram_re | output | 1 | RAM read enable |
| ram_raddr | output | 16 | RAM read byte address |
| ram_rdata | input | 16 | RAM read data, one cycle after ram_re |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | 16 | RAM write byte address |
| ram_wdata | output | 16 | RAM write data |

## Verification
The assertions assume three things about the inputs. The core never issues a held (stalled) memory-port request and a new one as different transactions without reissuing. Request and select inputs are stable and known between clock edges. The attached RAM returns read data exactly one cycle after `ram_re`, in read-before-write order. The bench follows these assumptions: it changes every input only at the falling clock edge, and it reissues a stalled memory-port request unchanged. Its RAM model reads the old word before applying a same-cycle write. Under these conditions the bench sweeps all sixteen register numbers over several bank bases and all 32 flag combinations.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned SELW    = 4;
  localparam int unsigned DROP_LO = 5;
  localparam int unsigned NFLAGS  = 5;

  localparam logic [DW-1:0] BASE_KEEP  = ~((DW'(1) << DROP_LO) - DW'(1));
  localparam logic [DW-1:0] BASE_RESET = 16'h0100;
  localparam logic [DW-1:0] ADDR_FLAGS = 16'hC000;
  localparam logic [DW-1:0] ADDR_BANK  = 16'hC002;

  // Byte address of a general register inside the current bank window.
  function automatic logic [DW-1:0] reg_byte_addr(input logic [DW-1:0] base,
                                                  input logic [SELW-1:0] sel);
    logic [DW-1:0] off;
    off = DW'(sel) << 1;
    return (base & BASE_KEEP) | off;
  endfunction

  // Flags word: Z, C, O, S, I from bit 0 upward, rest zero.
  function automatic logic [DW-1:0] pack_flags(input logic z, input logic c,
                                               input logic o, input logic s,
                                               input logic i);
    return {{(DW-NFLAGS){1'b0}}, i, s, o, c, z};
  endfunction
endpackage

// File: rtl/regwin_bank.sv
module regwin_bank
  import regwin_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= BASE_RESET & BASE_KEEP;
    else if (load) base_q <= load_val & BASE_KEEP;
  end
endmodule

// File: rtl/regwin_arb.sv
module regwin_arb
  import regwin_pkg::*;
(
  input  logic            rd_req,
  input  logic [SELW-1:0] rd_sel,
  input  logic            wr_req,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   base,
  input  logic            mem_hit,
  input  logic            mem_we,
  input  logic [DW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_wdata,
  output logic            mem_go,
  output logic            stall,
  output logic            ram_re,
  output logic [DW-1:0]   ram_raddr,
  output logic            ram_we,
  output logic [DW-1:0]   ram_waddr,
  output logic [DW-1:0]   ram_wdata
);
  logic          reg_busy;
  logic [DW-1:0] mem_word;

  assign reg_busy = rd_req | wr_req;
  assign stall    = mem_hit & reg_busy;
  assign mem_go   = mem_hit & ~reg_busy;
  assign mem_word = mem_addr & ~DW'(1);

  always_comb begin
    ram_re    = 1'b0;
    ram_raddr = '0;
    ram_we    = 1'b0;
    ram_waddr = '0;
    ram_wdata = '0;
    if (rd_req) begin
      ram_re    = 1'b1;
      ram_raddr = reg_byte_addr(base, rd_sel);
    end else if (mem_go && !mem_we) begin
      ram_re    = 1'b1;
      ram_raddr = mem_word;
    end
    if (wr_req) begin
      ram_we    = 1'b1;
      ram_waddr = reg_byte_addr(base, wr_sel);
      ram_wdata = wr_data;
    end else if (mem_go && mem_we) begin
      ram_we    = 1'b1;
      ram_waddr = mem_word;
      ram_wdata = mem_wdata;
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [SELW-1:0] rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  input  logic            wr_req,
  input  logic [SELW-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            cw_req,
  input  logic            cw_we,
  input  logic [DW-1:0]   cw_addr,
  input  logic [DW-1:0]   cw_wdata,
  output logic            cw_stall,
  output logic [DW-1:0]   mem_rdata,
  output logic            mem_rvalid,
  input  logic            flag_zero,
  input  logic            flag_carry,
  input  logic            flag_ovf,
  input  logic            flag_sign,
  input  logic            flag_ie,
  output logic            ram_re,
  output logic [DW-1:0]   ram_raddr,
  input  logic [DW-1:0]   ram_rdata,
  output logic            ram_we,
  output logic [DW-1:0]   ram_waddr,
  output logic [DW-1:0]   ram_wdata
);
  // Named internal events, visible to the bound checker.
  logic          hit_flags, hit_bank, mem_hit, mem_go;
  logic          bank_wr, flags_wr_drop, ctrl_rd;
  logic [DW-1:0] base_q, ctrl_word;
  logic          ctrl_sel_q, rd_valid_q, mem_rvalid_q;
  logic [DW-1:0] ctrl_data_q;

  assign hit_flags     = cw_req && (cw_addr & ~DW'(1)) == ADDR_FLAGS;
  assign hit_bank      = cw_req && (cw_addr & ~DW'(1)) == ADDR_BANK;
  assign mem_hit       = cw_req && !hit_flags && !hit_bank;
  assign bank_wr       = hit_bank && cw_we;
  assign flags_wr_drop = hit_flags && cw_we;
  assign ctrl_rd       = (hit_flags || hit_bank) && !cw_we;
  assign ctrl_word     = hit_bank ? base_q
                                  : pack_flags(flag_zero, flag_carry, flag_ovf,
                                               flag_sign, flag_ie);

  regwin_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bank_wr),
    .load_val(cw_wdata),
    .base_q  (base_q)
  );

  regwin_arb u_arb (
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .wr_req   (wr_req),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .base     (base_q),
    .mem_hit  (mem_hit),
    .mem_we   (cw_we),
    .mem_addr (cw_addr),
    .mem_wdata(cw_wdata),
    .mem_go   (mem_go),
    .stall    (cw_stall),
    .ram_re   (ram_re),
    .ram_raddr(ram_raddr),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q   <= 1'b0;
      mem_rvalid_q <= 1'b0;
      ctrl_sel_q   <= 1'b0;
      ctrl_data_q  <= '0;
    end else begin
      rd_valid_q   <= rd_req;
      mem_rvalid_q <= ctrl_rd || (mem_go && !cw_we);
      ctrl_sel_q   <= ctrl_rd;
      if (ctrl_rd) ctrl_data_q <= ctrl_word;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = ram_rdata;
  assign mem_rvalid = mem_rvalid_q;
  assign mem_rdata  = ctrl_sel_q ? ctrl_data_q : ram_rdata;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk
  import regwin_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic [SELW-1:0] rd_sel,
  input logic            wr_req,
  input logic [SELW-1:0] wr_sel,
  input logic            cw_req,
  input logic            cw_we,
  input logic [DW-1:0]   cw_wdata,
  input logic            cw_stall,
  input logic            ram_re,
  input logic [DW-1:0]   ram_raddr,
  input logic            ram_we,
  input logic [DW-1:0]   ram_waddr,
  input logic            rd_valid,
  input logic            mem_rvalid,
  input logic [DW-1:0]   base_q,
  input logic            bank_wr,
  input logic            flags_wr_drop
);
  // R1: register read address carries the register number, word aligned
  assert_rd_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (ram_re && ram_raddr[SELW:1] == rd_sel && !ram_raddr[0]));
  assert_wr_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (ram_we && ram_waddr[SELW:1] == wr_sel && !ram_waddr[0]));

  // R2: discarded low base bits never appear in the stored base
  always_comb begin
    if (rst_n) assert_base_low_R2: assert (base_q[DROP_LO-1:0] == '0);
  end

  // R4: a bank write is visible in the following cycle
  assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> base_q[DW-1:DROP_LO] == $past(cw_wdata[DW-1:DROP_LO]));

  // R6: a write to the flags address has no effect
  assert_flags_wr_noram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_wr_drop && !wr_req) |-> !ram_we);
  assert_flags_wr_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_wr_drop |=> $stable(base_q));

  // R7: register read data is flagged one cycle later
  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R10: stall only while the register port is busy, and no read answer follows
  assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cw_stall |-> (cw_req && (rd_req || wr_req)));
  assert_stall_noresp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cw_stall |=> !mem_rvalid);
endmodule

bind regwin_ctrl regwin_chk i_regwin_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .rd_sel       (rd_sel),
  .wr_req       (wr_req),
  .wr_sel       (wr_sel),
  .cw_req       (cw_req),
  .cw_we        (cw_we),
  .cw_wdata     (cw_wdata),
  .cw_stall     (cw_stall),
  .ram_re       (ram_re),
  .ram_raddr    (ram_raddr),
  .ram_we       (ram_we),
  .ram_waddr    (ram_waddr),
  .rd_valid     (rd_valid),
  .mem_rvalid   (mem_rvalid),
  .base_q       (base_q),
  .bank_wr      (bank_wr),
  .flags_wr_drop(flags_wr_drop)
);

// File: tb/test_regwin_ctrl.sv
`timescale 1ns/1ps
module test_regwin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 0, wr_req = 0, cw_req = 0, cw_we = 0;
  logic [3:0]  rd_sel = 0, wr_sel = 0;
  logic [15:0] wr_data = 0, cw_addr = 0, cw_wdata = 0;
  logic        flag_zero = 0, flag_carry = 0, flag_ovf = 0, flag_sign = 0, flag_ie = 0;
  logic [15:0] rd_data, mem_rdata, ram_raddr, ram_waddr, ram_wdata;
  logic        rd_valid, mem_rvalid, cw_stall, ram_re, ram_we;
  logic [15:0] ram_q = 0;
  logic [15:0] store [int unsigned];
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  regwin_ctrl i_regwin_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_req(wr_req), .wr_sel(wr_sel), .wr_data(wr_data),
    .cw_req(cw_req), .cw_we(cw_we), .cw_addr(cw_addr), .cw_wdata(cw_wdata),
    .cw_stall(cw_stall), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_ovf(flag_ovf),
    .flag_sign(flag_sign), .flag_ie(flag_ie),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  // Read-before-write synchronous RAM model.
  always @(posedge clk) begin
    if (ram_re) ram_q <= store.exists(ram_raddr[15:1]) ? store[ram_raddr[15:1]] : 16'h0000;
    if (ram_we) store[ram_waddr[15:1]] = ram_wdata;
  end

  function automatic logic [15:0] exp_addr(input int b, input int n);
    return 16'((b / 32) * 32 + n * 2);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_req = 0; wr_req = 0; cw_req = 0; cw_we = 0;
  endtask

  task automatic cw_op(input logic we, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); idle();
    cw_req = 1; cw_we = we; cw_addr = a; cw_wdata = d;
  endtask

  task automatic cw_read(input logic [15:0] a, output logic [15:0] d);
    cw_op(1'b0, a, 16'h0);
    @(posedge clk); #1;
    check("R9 mem_rvalid", {15'b0, mem_rvalid}, 16'h1);
    d = mem_rdata;
    @(negedge clk); idle();
  endtask

  task automatic reg_write(input int n, input logic [15:0] d, input logic [15:0] ea);
    @(negedge clk); idle();
    wr_req = 1; wr_sel = 4'(n); wr_data = d; #1;
    check("R1 write address", ram_waddr, ea);
    @(negedge clk); idle();
  endtask

  task automatic reg_read(input int n, input logic [15:0] ea, output logic [15:0] d);
    @(negedge clk); idle();
    rd_req = 1; rd_sel = 4'(n); #1;
    check("R1 read address", ram_raddr, ea);
    @(posedge clk); #1;
    check("R7 rd_valid", {15'b0, rd_valid}, 16'h1);
    d = rd_data;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int bases [5] = '{'h0100, 'hFFFF, 'h1234, 'h0000, 'hABDF};
    repeat (3) @(posedge clk);
    #1;
    check("R7 rd_valid at reset", {15'b0, rd_valid}, 16'h0);
    check("R9 mem_rvalid at reset", {15'b0, mem_rvalid}, 16'h0);
    @(negedge clk); rst_n = 1;

    // R3: reset base and R14 address
    cw_read(16'hC002, v);
    check("R3 reset base", v, 16'h0100);
    @(negedge clk); idle(); rd_req = 1; rd_sel = 4'd14; #1;
    check("R3 R14 address", ram_raddr, 16'h011C);
    @(negedge clk); idle();

    // R1/R2/R4/R7: sweep all registers over several bases
    foreach (bases[k]) begin
      cw_op(1'b1, 16'hC002, 16'(bases[k])); #1;
      check("R4 bank write no stall", {15'b0, cw_stall}, 16'h0);
      @(negedge clk); idle();
      cw_read(16'hC002, v);
      check("R2 base readback", v, 16'((bases[k] / 32) * 32));
      for (int n = 0; n < 16; n++)
        reg_write(n, 16'(bases[k] ^ (n * 'h1111)), exp_addr(bases[k], n));
      for (int n = 0; n < 16; n++) begin
        reg_read(n, exp_addr(bases[k], n), v);
        check("R7 read data", v, 16'(bases[k] ^ (n * 'h1111)));
      end
    end

    // R4: same-cycle base write and register read uses old base (0xABC0)
    @(negedge clk); idle();
    cw_req = 1; cw_we = 1; cw_addr = 16'hC002; cw_wdata = 16'h2040;
    rd_req = 1; rd_sel = 4'd3; #1;
    check("R4 old base in same cycle", ram_raddr, exp_addr('hABDF, 3));
    check("R10 control never stalls", {15'b0, cw_stall}, 16'h0);
    @(negedge clk); idle(); rd_req = 1; rd_sel = 4'd3; #1;
    check("R4 new base next cycle", ram_raddr, 16'h2046);
    @(negedge clk); idle();

    // R5: all flag combinations
    for (int f = 0; f < 32; f++) begin
      {flag_ie, flag_sign, flag_ovf, flag_carry, flag_zero} = 5'(f);
      cw_read(16'hC000, v);
      check("R5 flags word", v, 16'(f));
    end

    // R6: writes to the flags address are dropped
    {flag_ie, flag_sign, flag_ovf, flag_carry, flag_zero} = 5'b10110;
    cw_op(1'b1, 16'hC000, 16'hFFFF); #1;
    check("R6 no RAM write", {15'b0, ram_we}, 16'h0);
    @(negedge clk); idle();
    cw_read(16'hC000, v);
    check("R6 flags unchanged", v, 16'h0016);
    cw_read(16'hC002, v);
    check("R6 base unchanged", v, 16'h2040);

    // R8: same-cycle read and write of one register returns old value
    reg_write(5, 16'hBEEF, 16'h204A);
    @(negedge clk); idle();
    rd_req = 1; rd_sel = 4'd5; wr_req = 1; wr_sel = 4'd5; wr_data = 16'h1234;
    @(posedge clk); #1;
    check("R8 old value", rd_data, 16'hBEEF);
    reg_read(5, 16'h204A, v);
    check("R8 new value after", v, 16'h1234);

    // R9: plain memory access, odd address cleared
    cw_op(1'b1, 16'h0401, 16'hCAFE); #1;
    check("R9 write address", ram_waddr, 16'h0400);
    @(negedge clk); idle();
    cw_read(16'h0400, v);
    check("R9 read data", v, 16'hCAFE);

    // R10: register port wins, memory port stalls
    @(negedge clk); idle();
    cw_req = 1; cw_we = 0; cw_addr = 16'h0400; rd_req = 1; rd_sel = 4'd5; #1;
    check("R10 stall", {15'b0, cw_stall}, 16'h1);
    check("R10 register address wins", ram_raddr, 16'h204A);
    @(posedge clk); #1;
    check("R10 no memory response", {15'b0, mem_rvalid}, 16'h0);
    @(negedge clk); idle();
    cw_req = 1; cw_we = 1; cw_addr = 16'h0400; cw_wdata = 16'h0BAD;
    wr_req = 1; wr_sel = 4'd6; wr_data = 16'h6666; #1;
    check("R10 write stall", {15'b0, cw_stall}, 16'h1);
    check("R10 register write wins", ram_wdata, 16'h6666);
    @(negedge clk); idle();
    cw_read(16'h0400, v);
    check("R10 stalled write dropped", v, 16'hCAFE);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule